// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block is the trap controller of a 32-bit hart that runs only in machine mode, together with the control and status registers that belong to it. The pipeline reports a synchronous exception by giving a cause code, the PC of the faulting instruction and its instruction word. Load and store units hand in a fault address whenever one is detected. Three interrupt lines (software, timer, external) arrive from the platform. Each cycle the unit decides whether a trap is taken. On a trap it gives the redirect target and updates the status, cause, return-address and trap-value registers.

A return-from-trap strobe restores the interrupt enable from its saved copy and presents the saved return address. In the same cycle it rechecks the pending interrupts, so an interrupt that the return unmasks is taken at once without running the return target. Software reaches the registers through a single-cycle port. Writes are registered and reads are combinational. The identity registers and the ISA register are constants set by parameters.

Top module: `mtrap_csr_unit`

## Requirements
- R1: The status register (0x300) keeps only bit 3 (global interrupt enable), bit 7 (saved enable) and bits 12:11 (previous privilege). All other bits read 0. It is 0 after reset.
- R2: The interrupt enable register (0x304) keeps only bits 3 (software), 7 (timer) and 11 (external). The pending register (0x344) shows the three interrupt lines at those bits, ignores writes, and no delegation mask is applied to either register.
- R3: When several enabled interrupts are pending, external (cause 11) is taken first, then software (cause 3), then timer (cause 7).
- R4: Interrupts can be taken when the privilege input is below 3, or when it is 3 and the global enable bit is set. Otherwise no interrupt trap is raised.
- R5: On an exception the return-address register (0x341) receives the faulting PC. On an interrupt it receives the next-instruction PC input.
- R6: For an illegal-instruction exception (cause 2) the trap-value register (0x343) receives the instruction word if its low two bits are 11. Otherwise it receives only the low 16 bits, zero-extended.
- R7: For any other exception the trap-value register receives the captured fault address, which is then cleared to 0. A fault address offered in the same cycle as the exception is the one used.
- R8: On trap entry the saved enable takes the old global enable, the global enable clears and the previous privilege becomes 11. The cause register (0x342) gets bit 31 set for interrupts, with the cause code in its low bits.
- R9: The trap target is the vector register (0x305) with its low two bits cleared. When the mode field (bits 1:0) is 01 and the trap is an interrupt, 4 times the cause is added to that base.
- R10: A return strobe copies the saved enable into the global enable, sets the saved enable to 1, and outputs the return-address register on ret_pc. An interrupt that the restored enable allows is taken in the same cycle, and the return address is kept as its return point.
- R11: The vendor (0xF11), architecture (0xF12) and implementation (0xF13) identity registers and the ISA register (0x301) ignore writes and read their parameter values. The defaults are 0x669, 0x80000003, 1 and 0x40001104.
- R12: The scratch (0x340), return-address and vector registers read back the value last written.
- R13: An exception in the same cycle as a pending interrupt or a return strobe wins. The interrupt is not taken and the return is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_lvl | input | 2 | Current privilege level (3 = machine) |
| exc_valid | input | 1 | Synchronous exception this cycle |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_instr | input | 32 | Instruction word of the faulting instruction |
| fault_valid | input | 1 | Fault address present this cycle |
| fault_addr | input | 32 | Faulting data address |
| next_pc | input | 32 | PC of the next instruction (interrupt return point) |
| irq_software | input | 1 | Machine software interrupt line |
| irq_timer | input | 1 | Machine timer interrupt line |
| irq_external | input | 1 | Machine external interrupt line |
| mret | input | 1 | Return-from-trap strobe |
| csr_we | input | 1 | Register write enable |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| trap_taken | output | 1 | Trap taken this cycle |
| trap_pc | output | 32 | Trap target PC |
| ret_pc | output | 32 | Return target from the return-address register |

## Verification
trap_taken, trap_pc, ret_pc and csr_rdata are combinational. They respond in the same cycle as the exception, interrupt, return or address input that causes them. Register updates from a trap, a return or a software write go through one register stage, so they become readable after the next rising edge. The bench changes every input on the falling edge and samples the combinational outputs one time unit later, before the rising edge that commits the cycle. It then reads the affected registers in a later low phase to check the committed state.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IRQ_N = 3;

    localparam logic [11:0] ADDR_STATUS  = 12'h300;
    localparam logic [11:0] ADDR_ISA     = 12'h301;
    localparam logic [11:0] ADDR_IE      = 12'h304;
    localparam logic [11:0] ADDR_TVEC    = 12'h305;
    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_EPC     = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;
    localparam logic [11:0] ADDR_TVAL    = 12'h343;
    localparam logic [11:0] ADDR_IP      = 12'h344;
    localparam logic [11:0] ADDR_VENDOR  = 12'hF11;
    localparam logic [11:0] ADDR_ARCH    = 12'hF12;
    localparam logic [11:0] ADDR_IMPL    = 12'hF13;

    localparam logic [XLEN-1:0] STATUS_KEEP = 32'h0000_1888;
    localparam int unsigned     CAUSE_ILLEGAL = 2;

    // Interrupt slot i in priority order: 0 external, 1 software, 2 timer.
    // The cause code equals the bit position in the enable/pending words.
    function automatic int unsigned irq_code(input int unsigned idx);
        case (idx)
            0:       return 11;
            1:       return 3;
            default: return 7;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] irq_to_word(input logic [IRQ_N-1:0] v);
        logic [XLEN-1:0] w;
        w = '0;
        for (int i = 0; i < IRQ_N; i++) w[irq_code(i)] = v[i];
        return w;
    endfunction

    function automatic logic [IRQ_N-1:0] word_to_irq(input logic [XLEN-1:0] w);
        logic [IRQ_N-1:0] v;
        for (int i = 0; i < IRQ_N; i++) v[i] = w[irq_code(i)];
        return v;
    endfunction

    typedef struct packed {
        logic       gie;
        logic       saved_ie;
        logic [1:0] prev_priv;
    } status_t;

    typedef struct packed {
        status_t         st;
        logic [IRQ_N-1:0] ie;
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] fault;
    } csr_state_t;

endpackage

// File: rtl/mtrap_irq_select.sv
module mtrap_irq_select
    import mtrap_pkg::*;
#(
    parameter int unsigned N       = IRQ_N,
    parameter int unsigned CAUSE_W = 5
) (
    input  logic [N-1:0]       pend,
    input  logic [N-1:0]       ena,
    input  logic               glb_en,
    output logic               take,
    output logic [CAUSE_W-1:0] cause
);
    logic [N-1:0] req;
    logic [N-1:0] grant;
    logic [N:0]   seen;

    assign req     = pend & ena & {N{glb_en}};
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_prio
        assign grant[g]  = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    always_comb begin
        cause = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) cause = cause | CAUSE_W'(irq_code(i));
    end

    assign take = seen[N];

    always_comb begin
        assert_grant_single_R3: assert ($onehot0(grant));
    end
endmodule

// File: rtl/mtrap_vector_calc.sv
module mtrap_vector_calc
    import mtrap_pkg::*;
#(
    parameter int unsigned CAUSE_W = 5
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target
);
    localparam logic [1:0] MODE_VECTORED = 2'b01;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = {tvec[XLEN-1:2], 2'b00};
    assign offset = XLEN'(cause) << 2;
    assign target = (is_irq && tvec[1:0] == MODE_VECTORED) ? base + offset : base;
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
    import mtrap_pkg::*;
#(
    parameter int unsigned     CAUSE_W    = 5,
    parameter logic [XLEN-1:0] VENDOR_ID  = 32'h0000_0669,
    parameter logic [XLEN-1:0] ARCH_ID    = 32'h8000_0003,
    parameter logic [XLEN-1:0] IMPL_ID    = 32'h0000_0001,
    parameter logic [XLEN-1:0] ISA_VALUE  = 32'h4000_1104,
    parameter logic [XLEN-1:0] RESET_TVEC = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         priv_lvl,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [XLEN-1:0]    exc_pc,
    input  logic [XLEN-1:0]    exc_instr,
    input  logic               fault_valid,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [XLEN-1:0]    next_pc,
    input  logic               irq_software,
    input  logic               irq_timer,
    input  logic               irq_external,
    input  logic               mret,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               trap_taken,
    output logic [XLEN-1:0]    trap_pc,
    output logic [XLEN-1:0]    ret_pc
);
    localparam int unsigned PAD_W    = XLEN - 1 - CAUSE_W;
    localparam logic [1:0]  PRIV_TOP = 2'b11;

    csr_state_t state_q, state_d;

    logic [IRQ_N-1:0]   pend;
    logic               gie_eff;
    logic               glb_en;
    logic               irq_take;
    logic [CAUSE_W-1:0] irq_cause;
    logic               irq_taken;
    logic [CAUSE_W-1:0] trap_cause;
    logic [XLEN-1:0]    fault_now;

    assign pend    = {irq_timer, irq_software, irq_external};
    assign gie_eff = mret ? state_q.st.saved_ie : state_q.st.gie;
    assign glb_en  = (priv_lvl != PRIV_TOP) || gie_eff;

    mtrap_irq_select #(
        .N       (IRQ_N),
        .CAUSE_W (CAUSE_W)
    ) u_irq_select (
        .pend   (pend),
        .ena    (state_q.ie),
        .glb_en (glb_en),
        .take   (irq_take),
        .cause  (irq_cause)
    );

    assign irq_taken  = irq_take & ~exc_valid;
    assign trap_taken = exc_valid | irq_taken;
    assign trap_cause = exc_valid ? exc_cause : irq_cause;
    assign fault_now  = fault_valid ? fault_addr : state_q.fault;

    mtrap_vector_calc #(
        .CAUSE_W (CAUSE_W)
    ) u_vector_calc (
        .tvec   (state_q.tvec),
        .is_irq (irq_taken),
        .cause  (trap_cause),
        .target (trap_pc)
    );

    assign ret_pc = state_q.epc;

    // next-state logic
    always_comb begin
        state_d = state_q;

        if (fault_valid) state_d.fault = fault_addr;

        if (csr_we) begin
            case (csr_addr)
                ADDR_STATUS: begin
                    state_d.st.gie       = csr_wdata[3];
                    state_d.st.saved_ie  = csr_wdata[7];
                    state_d.st.prev_priv = csr_wdata[12:11];
                end
                ADDR_IE:      state_d.ie      = word_to_irq(csr_wdata);
                ADDR_TVEC:    state_d.tvec    = csr_wdata;
                ADDR_SCRATCH: state_d.scratch = csr_wdata;
                ADDR_EPC:     state_d.epc     = csr_wdata;
                ADDR_CAUSE:   state_d.cause   = csr_wdata;
                ADDR_TVAL:    state_d.tval    = csr_wdata;
                default: ;
            endcase
        end

        if (exc_valid) begin
            state_d.epc   = exc_pc;
            state_d.cause = {1'b0, {PAD_W{1'b0}}, exc_cause};
            if (exc_cause == CAUSE_W'(CAUSE_ILLEGAL)) begin
                state_d.tval = (exc_instr[1:0] == 2'b11) ? exc_instr
                                                         : {16'h0000, exc_instr[15:0]};
            end else begin
                state_d.tval  = fault_now;
                state_d.fault = '0;
            end
            state_d.st.saved_ie  = state_q.st.gie;
            state_d.st.gie       = 1'b0;
            state_d.st.prev_priv = PRIV_TOP;
        end else if (irq_taken) begin
            state_d.epc          = mret ? state_q.epc : next_pc;
            state_d.cause        = {1'b1, {PAD_W{1'b0}}, irq_cause};
            state_d.st.saved_ie  = gie_eff;
            state_d.st.gie       = 1'b0;
            state_d.st.prev_priv = PRIV_TOP;
        end else if (mret) begin
            state_d.st.gie      = state_q.st.saved_ie;
            state_d.st.saved_ie = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.tvec <= RESET_TVEC;
        end else begin
            state_q <= state_d;
        end
    end

    // read port
    always_comb begin
        case (csr_addr)
            ADDR_STATUS:  csr_rdata = {19'b0, state_q.st.prev_priv, 3'b0,
                                       state_q.st.saved_ie, 3'b0, state_q.st.gie, 3'b0};
            ADDR_ISA:     csr_rdata = ISA_VALUE;
            ADDR_IE:      csr_rdata = irq_to_word(state_q.ie);
            ADDR_IP:      csr_rdata = irq_to_word(pend);
            ADDR_TVEC:    csr_rdata = state_q.tvec;
            ADDR_SCRATCH: csr_rdata = state_q.scratch;
            ADDR_EPC:     csr_rdata = state_q.epc;
            ADDR_CAUSE:   csr_rdata = state_q.cause;
            ADDR_TVAL:    csr_rdata = state_q.tval;
            ADDR_VENDOR:  csr_rdata = VENDOR_ID;
            ADDR_ARCH:    csr_rdata = ARCH_ID;
            ADDR_IMPL:    csr_rdata = IMPL_ID;
            default:      csr_rdata = '0;
        endcase
    end

    // assertions
    assert_status_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_STATUS) |-> ((csr_rdata & ~STATUS_KEEP) == '0));

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == PRIV_TOP && !state_q.st.gie && !mret && !exc_valid) |-> !trap_taken);

    assert_exc_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (state_q.epc == $past(exc_pc)));

    assert_trap_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (!state_q.st.gie && state_q.st.prev_priv == PRIV_TOP));

    assert_ret_saved_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap_taken) |=> state_q.st.saved_ie);

    assert_vendor_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_VENDOR) |-> (csr_rdata == VENDOR_ID));
endmodule

// File: tb/mtrap_csr_unit_tb.sv
module mtrap_csr_unit_tb;
    import mtrap_pkg::*;

    localparam time CLK_PERIOD = 10;
    localparam int  CW         = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      priv_lvl = 2'b11;
    logic            exc_valid = 1'b0;
    logic [CW-1:0]   exc_cause = '0;
    logic [31:0]     exc_pc = '0, exc_instr = '0;
    logic            fault_valid = 1'b0;
    logic [31:0]     fault_addr = '0, next_pc = '0;
    logic            irq_software = 1'b0, irq_timer = 1'b0, irq_external = 1'b0;
    logic            mret = 1'b0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [31:0]     csr_wdata = '0;
    logic [31:0]     csr_rdata, trap_pc, ret_pc;
    logic            trap_taken;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtrap_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc),
        .exc_instr(exc_instr), .fault_valid(fault_valid), .fault_addr(fault_addr),
        .next_pc(next_pc), .irq_software(irq_software), .irq_timer(irq_timer),
        .irq_external(irq_external), .mret(mret), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_taken(trap_taken), .trap_pc(trap_pc), .ret_pc(ret_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic expect_csr(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        csr_addr = a;
        #1;
        chk(req, csr_rdata, exp);
    endtask

    // One cycle of trap-related stimulus; outputs sampled before the committing edge.
    task automatic pulse(input logic ev, input logic [CW-1:0] cause, input logic [31:0] pc,
                         input logic [31:0] instr, input logic fv, input logic [31:0] fa,
                         input logic [2:0] lines, input logic ret,
                         output logic tt, output logic [31:0] tpc, output logic [31:0] rpc);
        @(negedge clk);
        exc_valid = ev; exc_cause = cause; exc_pc = pc; exc_instr = instr;
        fault_valid = fv; fault_addr = fa;
        {irq_external, irq_software, irq_timer} = lines;
        mret = ret;
        #1;
        tt = trap_taken; tpc = trap_pc; rpc = ret_pc;
        @(negedge clk);
        exc_valid = 1'b0; fault_valid = 1'b0; mret = 1'b0;
        {irq_external, irq_software, irq_timer} = 3'b000;
    endtask

    task automatic t_reset();
        expect_csr("R1 reset status", ADDR_STATUS, 32'h0);
        expect_csr("R2 reset enable", ADDR_IE, 32'h0);
        chk("R4 no trap after reset", {31'b0, trap_taken}, 32'h0);
        expect_csr("R11 vendor", ADDR_VENDOR, 32'h669);
        expect_csr("R11 arch", ADDR_ARCH, 32'h8000_0003);
        expect_csr("R11 impl", ADDR_IMPL, 32'h1);
        expect_csr("R11 isa", ADDR_ISA, 32'h4000_1104);
    endtask

    task automatic t_status_mask();
        wr(ADDR_STATUS, 32'hFFFF_FFFF);
        expect_csr("R1 status all ones", ADDR_STATUS, 32'h0000_1888);
        wr(ADDR_STATUS, 32'h0000_0000);
        expect_csr("R1 status cleared", ADDR_STATUS, 32'h0);
    endtask

    task automatic t_id_readonly();
        wr(ADDR_VENDOR, 32'h0); wr(ADDR_ARCH, 32'h0); wr(ADDR_IMPL, 32'hFFFF_FFFF);
        wr(ADDR_ISA, 32'h0);
        expect_csr("R11 vendor after write", ADDR_VENDOR, 32'h669);
        expect_csr("R11 arch after write", ADDR_ARCH, 32'h8000_0003);
        expect_csr("R11 impl after write", ADDR_IMPL, 32'h1);
        expect_csr("R11 isa after write", ADDR_ISA, 32'h4000_1104);
    endtask

    task automatic t_plain_rw();
        wr(ADDR_SCRATCH, 32'hA5A5_5A5A);
        wr(ADDR_EPC, 32'h1000_0004);
        wr(ADDR_TVEC, 32'h0000_0100);
        expect_csr("R12 scratch", ADDR_SCRATCH, 32'hA5A5_5A5A);
        expect_csr("R12 epc", ADDR_EPC, 32'h1000_0004);
        expect_csr("R12 tvec", ADDR_TVEC, 32'h0000_0100);
    endtask

    task automatic t_irq_masks();
        priv_lvl = 2'b11;
        wr(ADDR_IE, 32'hFFFF_FFFF);
        expect_csr("R2 enable mask", ADDR_IE, 32'h0000_0888);
        @(negedge clk);
        {irq_external, irq_software, irq_timer} = 3'b111;
        wr(ADDR_IP, 32'h0);
        expect_csr("R2 pending shows lines, write ignored", ADDR_IP, 32'h0000_0888);
        chk("R4 machine level with enable clear", {31'b0, trap_taken}, 32'h0);
        {irq_external, irq_software, irq_timer} = 3'b010;
        expect_csr("R2 pending software only", ADDR_IP, 32'h0000_0008);
        {irq_external, irq_software, irq_timer} = 3'b000;
    endtask

    task automatic t_enable_rule();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b11;
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b010, 1'b0, tt, tpc, rpc);
        chk("R4 blocked at machine level", {31'b0, tt}, 32'h0);
        priv_lvl = 2'b01;
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b010, 1'b0, tt, tpc, rpc);
        chk("R4 taken below machine level", {31'b0, tt}, 32'h1);
        chk("R9 direct target", tpc, 32'h0000_0100);
        expect_csr("R8 irq cause", ADDR_CAUSE, 32'h8000_0003);
    endtask

    task automatic t_priority();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b00;
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b111, 1'b0, tt, tpc, rpc);
        expect_csr("R3 external first", ADDR_CAUSE, 32'h8000_000B);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b011, 1'b0, tt, tpc, rpc);
        expect_csr("R3 software over timer", ADDR_CAUSE, 32'h8000_0003);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b001, 1'b0, tt, tpc, rpc);
        expect_csr("R3 timer alone", ADDR_CAUSE, 32'h8000_0007);
    endtask

    task automatic t_vectored();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b00;
        wr(ADDR_TVEC, 32'h0000_0201);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b001, 1'b0, tt, tpc, rpc);
        chk("R9 vectored timer", tpc, 32'h0000_021C);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b100, 1'b0, tt, tpc, rpc);
        chk("R9 vectored external", tpc, 32'h0000_022C);
        pulse(1'b1, 5'd5, 32'h80, 0, 1'b0, 0, 3'b000, 1'b0, tt, tpc, rpc);
        chk("R9 exception uses base", tpc, 32'h0000_0200);
        wr(ADDR_TVEC, 32'h0000_0100);
    endtask

    task automatic t_irq_entry();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b11;
        wr(ADDR_STATUS, 32'h0000_0008);
        next_pc = 32'h0000_2468;
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b010, 1'b0, tt, tpc, rpc);
        chk("R4 machine level with enable set", {31'b0, tt}, 32'h1);
        expect_csr("R5 interrupt return point", ADDR_EPC, 32'h0000_2468);
        expect_csr("R8 status after irq entry", ADDR_STATUS, 32'h0000_1880);
    endtask

    task automatic t_illegal();
        logic tt; logic [31:0] tpc, rpc;
        pulse(1'b1, 5'd2, 32'h3000, 32'h1234_5673, 1'b0, 0, 3'b000, 1'b0, tt, tpc, rpc);
        expect_csr("R6 full word", ADDR_TVAL, 32'h1234_5673);
        expect_csr("R5 exception pc", ADDR_EPC, 32'h0000_3000);
        expect_csr("R8 exception cause", ADDR_CAUSE, 32'h0000_0002);
        expect_csr("R8 status after exception", ADDR_STATUS, 32'h0000_1800);
        pulse(1'b1, 5'd2, 32'h3004, 32'hABCD_1231, 1'b0, 0, 3'b000, 1'b0, tt, tpc, rpc);
        expect_csr("R6 compressed parcel", ADDR_TVAL, 32'h0000_1231);
    endtask

    task automatic t_fault_capture();
        logic tt; logic [31:0] tpc, rpc;
        pulse(1'b0, '0, 0, 0, 1'b1, 32'hDEAD_0010, 3'b000, 1'b0, tt, tpc, rpc);
        pulse(1'b1, 5'd5, 32'h3100, 0, 1'b0, 0, 3'b000, 1'b0, tt, tpc, rpc);
        expect_csr("R7 captured address", ADDR_TVAL, 32'hDEAD_0010);
        pulse(1'b1, 5'd7, 32'h3104, 0, 1'b0, 0, 3'b000, 1'b0, tt, tpc, rpc);
        expect_csr("R7 capture cleared", ADDR_TVAL, 32'h0);
        pulse(1'b1, 5'd4, 32'h3108, 0, 1'b1, 32'h0000_0077, 3'b000, 1'b0, tt, tpc, rpc);
        expect_csr("R7 same-cycle address", ADDR_TVAL, 32'h0000_0077);
    endtask

    task automatic t_return();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b11;
        wr(ADDR_STATUS, 32'h0000_0080);
        wr(ADDR_EPC, 32'h0000_4000);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b000, 1'b1, tt, tpc, rpc);
        chk("R10 return target", rpc, 32'h0000_4000);
        chk("R10 plain return no trap", {31'b0, tt}, 32'h0);
        expect_csr("R10 status after return", ADDR_STATUS, 32'h0000_0088);
        wr(ADDR_STATUS, 32'h0000_0080);
        pulse(1'b0, '0, 0, 0, 1'b0, 0, 3'b010, 1'b1, tt, tpc, rpc);
        chk("R10 return unmasks pending irq", {31'b0, tt}, 32'h1);
        expect_csr("R10 irq cause on return", ADDR_CAUSE, 32'h8000_0003);
        expect_csr("R10 return point kept", ADDR_EPC, 32'h0000_4000);
        expect_csr("R10 status after return+irq", ADDR_STATUS, 32'h0000_1880);
    endtask

    task automatic t_exc_wins();
        logic tt; logic [31:0] tpc, rpc;
        priv_lvl = 2'b00;
        pulse(1'b1, 5'd5, 32'h5000, 0, 1'b0, 0, 3'b100, 1'b1, tt, tpc, rpc);
        chk("R13 target is base", tpc, 32'h0000_0100);
        expect_csr("R13 exception cause", ADDR_CAUSE, 32'h0000_0005);
        expect_csr("R13 exception pc", ADDR_EPC, 32'h0000_5000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status_mask();
        t_id_readonly();
        t_plain_rw();
        t_irq_masks();
        t_enable_rule();
        t_priority();
        t_vectored();
        t_irq_entry();
        t_illegal();
        t_fault_capture();
        t_return();
        t_exc_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule